// File: doc/BRIEF.md
# Single-wire pulse-width brightness receiver

This block takes a five-bit brightness code from one line that rests high and is pulled low by the sender, as on an open-drain bus. Only the length of each low excursion carries information. The block samples the line with the system clock and times each low pulse in microseconds. It sorts the pulse into one of four kinds: data one, data zero, load command or junk. Data bits shift into a five-bit register. A load command copies that register into the brightness register, and the new code takes effect at once.

The loaded code drives a small datapath. It produces the feedback target voltage as an integer in units of 10 µV: 980 plus 568 times the code. A low enable input clears all of the state, so after re-enable the output stays at the minimum level until a fresh code is loaded. Pulse timing uses a microsecond tick derived from the clock, and the number of clocks per microsecond is a parameter.

Top module: `swire_dim_rx`

## Requirements
- R1: After reset, code_o is 0, target_o is 980 and load_stb_o is 0.
- R2: A low pulse of 15 µs to 45 µs shifts a 1 into the LSB of the shift register. The older bits move one place toward the MSB.
- R3: A low pulse of 90 µs to 120 µs shifts a 0 into the LSB in the same way.
- R4: A low pulse longer than 215 µs copies the shift register into code_o. During the same clock, load_stb_o is high for exactly one cycle.
- R5: Bits arrive MSB first. The pulses 1,0,1,0,0 followed by a load give code_o = 20 (binary 10100).
- R6: A low pulse outside all three windows (under 15 µs, 45–90 µs, 120–215 µs) leaves the shift register unchanged and raises no strobe.
- R7: A high gap shorter than 3 µs does not end a pulse. The low time keeps accumulating through it, so the whole excursion is classified as one pulse.
- R8: While en_i is low, the shift register and code_o are held at 0. After en_i returns high, code_o stays 0 until a load occurs. A load with no new bits loads 0.
- R9: target_o equals 980 + 568 × code_o. Code 0 gives 980 and code 31 gives 18588.
- R10: code_o changes only in a cycle where load_stb_o is high, or in the cycle after en_i was low.
- R11: The low-time counter saturates, so a 600 µs low pulse is still decoded as a load.
- R12: A load does not clear the shift register. Bits received afterwards shift onto the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; low clears all state |
| line_i | input | 1 | Asynchronous single-wire line, idle high |
| code_o | output | CODE_W | Loaded brightness code |
| target_o | output | TGT_W | Feedback target in units of 10 µV |
| load_stb_o | output | 1 | One-cycle pulse on each brightness update |

## Verification
Any error inside the block stays hidden until the next load command. A wrong shift register, a misclassified bit or a glitch that split a pulse therefore appears as a wrong code_o, and a wrong target_o, a few clocks after the line has been high for 3 µs at the end of a load pulse. A clearing fault appears sooner: code_o is not 0 right after en_i falls. A faulty target datapath shows up in every cycle as a mismatch against 980 + 568 × code. Frames are built so that merged, dropped or extra bits each give a different loaded code.

// File: rtl/swire_pkg.sv
package swire_pkg;
  typedef enum logic [1:0] {
    PK_BAD  = 2'd0,
    PK_ONE  = 2'd1,
    PK_ZERO = 2'd2,
    PK_LOAD = 2'd3
  } pulse_kind_e;
endpackage

// File: rtl/swire_sync.sv
module swire_sync #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/swire_pulse_timer.sv
module swire_pulse_timer #(
  parameter int CLK_PER_US = 50,
  parameter int THIGH_MIN  = 3,
  parameter int CNT_W      = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             line_i,
  output logic             done_o,
  output logic [CNT_W-1:0] len_o
);
  localparam int PRE_W = $clog2(CLK_PER_US + 1);
  localparam int HI_W  = $clog2(THIGH_MIN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} tstate_e;

  tstate_e          state_q;
  logic [PRE_W-1:0] pre_q;
  logic             tick;
  logic [CNT_W-1:0] low_q, snap_q, low_inc;
  logic [HI_W-1:0]  hi_q;

  assign tick    = (pre_q == PRE_W'(CLK_PER_US - 1));
  assign low_inc = (tick && low_q != CNT_MAX) ? low_q + 1'b1 : low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else if (tick || !en_i) pre_q <= '0;
    else pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      low_q   <= '0;
      snap_q  <= '0;
      hi_q    <= '0;
      done_o  <= 1'b0;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
      low_q   <= '0;
      hi_q    <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (!line_i) begin
          state_q <= ST_LOW;
          low_q   <= '0;
        end
        ST_LOW: begin
          low_q <= low_inc;
          if (line_i) begin
            state_q <= ST_HIGH;
            snap_q  <= low_q;
            hi_q    <= '0;
          end
        end
        ST_HIGH: begin
          // low counter runs through a short high gap
          low_q <= low_inc;
          if (!line_i) begin
            state_q <= ST_LOW;
          end else if (tick) begin
            if (hi_q == HI_W'(THIGH_MIN - 1)) begin
              state_q <= ST_IDLE;
              done_o  <= 1'b1;
            end else begin
              hi_q <= hi_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign len_o = snap_q;
endmodule

// File: rtl/swire_classify.sv
module swire_classify
  import swire_pkg::*;
#(
  parameter int CNT_W   = 9,
  parameter int T1_MIN  = 15,
  parameter int T1_MAX  = 45,
  parameter int T0_MIN  = 90,
  parameter int T0_MAX  = 120,
  parameter int TLD_MIN = 215
) (
  input  logic [CNT_W-1:0] len_i,
  output pulse_kind_e      kind_o
);
  always_comb begin
    if (len_i > CNT_W'(TLD_MIN))
      kind_o = PK_LOAD;
    else if (len_i >= CNT_W'(T1_MIN) && len_i <= CNT_W'(T1_MAX))
      kind_o = PK_ONE;
    else if (len_i >= CNT_W'(T0_MIN) && len_i <= CNT_W'(T0_MAX))
      kind_o = PK_ZERO;
    else
      kind_o = PK_BAD;
  end
endmodule

// File: rtl/swire_target.sv
module swire_target #(
  parameter int CODE_W = 5,
  parameter int BASE   = 980,
  parameter int STEP   = 568,
  parameter int TGT_W  = 15
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [TGT_W-1:0]  target_o
);
  assign target_o = TGT_W'(BASE) + TGT_W'(STEP) * TGT_W'(code_i);
endmodule

// File: rtl/swire_dim_rx.sv
module swire_dim_rx
  import swire_pkg::*;
#(
  parameter int CLK_PER_US = 50,
  parameter int CODE_W     = 5,
  parameter int T1_MIN     = 15,
  parameter int T1_MAX     = 45,
  parameter int T0_MIN     = 90,
  parameter int T0_MAX     = 120,
  parameter int TLD_MIN    = 215,
  parameter int THIGH_MIN  = 3,
  parameter int BASE       = 980,
  parameter int STEP       = 568,
  localparam int TGT_W     = $clog2(BASE + STEP * ((1 << CODE_W) - 1) + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              line_i,
  output logic [CODE_W-1:0] code_o,
  output logic [TGT_W-1:0]  target_o,
  output logic              load_stb_o
);
  localparam int CNT_W = $clog2(TLD_MIN + 1) + 1;

  logic             line_s, done;
  logic [CNT_W-1:0] len;
  pulse_kind_e      kind;
  logic [CODE_W-1:0] shift_q, code_q;
  logic             stb_q;

  swire_sync #(.RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(line_i), .q_o(line_s)
  );

  swire_pulse_timer #(
    .CLK_PER_US(CLK_PER_US), .THIGH_MIN(THIGH_MIN), .CNT_W(CNT_W)
  ) u_timer (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(en_i), .line_i(line_s),
    .done_o(done), .len_o(len)
  );

  swire_classify #(
    .CNT_W(CNT_W), .T1_MIN(T1_MIN), .T1_MAX(T1_MAX),
    .T0_MIN(T0_MIN), .T0_MAX(T0_MAX), .TLD_MIN(TLD_MIN)
  ) u_cls (
    .len_i(len), .kind_o(kind)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      code_q  <= '0;
      stb_q   <= 1'b0;
    end else if (!en_i) begin
      shift_q <= '0;
      code_q  <= '0;
      stb_q   <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (done) begin
        unique case (kind)
          PK_ONE:  shift_q <= {shift_q[CODE_W-2:0], 1'b1};
          PK_ZERO: shift_q <= {shift_q[CODE_W-2:0], 1'b0};
          PK_LOAD: begin
            code_q <= shift_q;
            stb_q  <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  swire_target #(
    .CODE_W(CODE_W), .BASE(BASE), .STEP(STEP), .TGT_W(TGT_W)
  ) u_tgt (
    .code_i(code_q), .target_o(target_o)
  );

  assign code_o     = code_q;
  assign load_stb_o = stb_q;
endmodule

// File: rtl/swire_dim_rx_chk.sv
module swire_dim_rx_chk #(
  parameter int CODE_W = 5,
  parameter int TGT_W  = 15,
  parameter int BASE   = 980
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [CODE_W-1:0] code_o,
  input logic [TGT_W-1:0]  target_o,
  input logic              load_stb_o
);
  // R4
  stb_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_stb_o |=> !load_stb_o);
  // R4
  stb_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_stb_o |-> $past(en_i));
  // R10
  code_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_o) |-> (load_stb_o || !$past(en_i)));
  // R8
  en_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (code_o == '0));
  // R9
  tgt_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o == '0) |-> (target_o == TGT_W'(BASE)));
  // R9
  tgt_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o > $past(code_o)) |-> (target_o > $past(target_o)));
endmodule

bind swire_dim_rx swire_dim_rx_chk #(
  .CODE_W(CODE_W), .TGT_W(TGT_W), .BASE(BASE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .code_o(code_o),
  .target_o(target_o), .load_stb_o(load_stb_o)
);

// File: tb/swire_dim_rx_tb.sv
module swire_dim_rx_tb;
  localparam int CPU = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b1;
  logic        line_i = 1'b1;
  logic [4:0]  code_o;
  logic [14:0] target_o;
  logic        load_stb_o;

  swire_dim_rx #(.CLK_PER_US(CPU)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .line_i(line_i),
    .code_o(code_o), .target_o(target_o), .load_stb_o(load_stb_o)
  );

  always #10 clk_i = ~clk_i;

  int checks = 0, errors = 0;
  int sh = 0, exp_code = 0, stb_cnt = 0, cyc = 0;
  bit cmp_en = 1'b0;

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  always @(negedge clk_i) begin
    if (load_stb_o) stb_cnt++;
    if (rst_ni && cmp_en) begin
      chk(int'(code_o) == exp_code, "R10 code vs model", int'(code_o), exp_code);
      chk(int'(target_o) == 980 + 568 * exp_code, "R9 target", int'(target_o),
          980 + 568 * exp_code);
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog R4 run did not end actual=%0d expected=0", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_us(int us);
    repeat (us * CPU) @(posedge clk_i);
  endtask

  // behavioural classification from the requirement windows
  task automatic model(int us);
    if (us >= 15 && us <= 45) sh = ((sh << 1) | 1) & 31;       // R2
    else if (us >= 90 && us <= 120) sh = (sh << 1) & 31;       // R3
    else if (us > 215) exp_code = sh;                          // R4
    // otherwise discarded: R6
  endtask

  task automatic send_parts(int a, int g, int b);
    int total = a + g + b;
    int s0 = stb_cnt;
    bit ld = total > 215;
    if (ld) cmp_en = 1'b0;
    @(negedge clk_i) line_i = 1'b0;
    wait_us(a);
    if (g > 0) begin
      @(negedge clk_i) line_i = 1'b1;
      wait_us(g);
      @(negedge clk_i) line_i = 1'b0;
      wait_us(b);
    end
    @(negedge clk_i) line_i = 1'b1;
    wait_us(10);
    model(total);
    @(negedge clk_i);
    if (ld) begin
      chk(stb_cnt == s0 + 1, "R4 one strobe per load", stb_cnt - s0, 1);
      chk(int'(code_o) == exp_code, "R4 loaded code", int'(code_o), exp_code);
      cmp_en = 1'b1;
    end else begin
      chk(stb_cnt == s0, "R6 no strobe without load", stb_cnt - s0, 0);
    end
  endtask

  task automatic send(int us);
    send_parts(us, 0, 0);
  endtask

  initial begin
    repeat (5) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i);
    chk(code_o == 5'd0, "R1 reset code", int'(code_o), 0);
    chk(target_o == 15'd980, "R1 reset target", int'(target_o), 980);
    chk(load_stb_o == 1'b0, "R1 reset strobe", int'(load_stb_o), 0);
    cmp_en = 1'b1;
    wait_us(5);

    // R5: 1,0,1,0,0 then load -> 20
    send(30); send(105); send(30); send(105); send(105);
    send(230);
    chk(int'(code_o) == 20, "R5 msb first", int'(code_o), 20);

    // R12: two more ones onto 10100 -> 10011
    send(25); send(40);
    send(230);
    chk(int'(code_o) == 19, "R12 shift kept after load", int'(code_o), 19);

    // R6: invalid pulses leave shift alone (still 10011)
    send(8); send(60); send(160);
    send(230);
    chk(int'(code_o) == 19, "R6 invalid discarded", int'(code_o), 19);

    // R7: 80 low, 1 high, 25 low = one 106 us zero
    send_parts(80, 1, 25);
    send(230);
    chk(int'(code_o) == 6, "R7 glitch merged", int'(code_o), 6);

    // R2 / R11 / R9: five ones with a 600 us load -> 31
    for (int i = 0; i < 5; i++) send(20 + 5 * i);
    send(600);
    chk(int'(code_o) == 31, "R11 saturating load", int'(code_o), 31);
    chk(int'(target_o) == 18588, "R9 full scale", int'(target_o), 18588);

    // R3: five zeros -> 0
    for (int i = 0; i < 5; i++) send(92 + 6 * i);
    send(230);
    chk(int'(code_o) == 0, "R3 zeros", int'(code_o), 0);

    // R8: load 1, then disable
    send(30); send(230);
    chk(int'(code_o) == 1, "R8 precondition", int'(code_o), 1);
    send(30);
    cmp_en = 1'b0;
    @(negedge clk_i) en_i = 1'b0;
    wait_us(5);
    @(negedge clk_i);
    chk(int'(code_o) == 0, "R8 cleared while disabled", int'(code_o), 0);
    @(negedge clk_i) en_i = 1'b1;
    sh = 0; exp_code = 0;
    cmp_en = 1'b1;
    wait_us(20);
    chk(int'(code_o) == 0, "R8 stays minimum", int'(code_o), 0);
    send(230);
    chk(int'(code_o) == 0, "R8 shift cleared", int'(code_o), 0);

    wait_us(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule